// File: doc/BRIEF.md
# Packed SIMD Lane Shift Unit

This block is a single-cycle execution unit for packed shifts on a 32-bit data word. The word is treated as four byte lanes, two halfword lanes or one full-word lane, according to the operation. The unit offers left shifts (wrapping or saturating), logical right shifts, arithmetic right shifts and rounding arithmetic right shifts. Each lane is shifted on its own, and no bit crosses a lane boundary.

A caller presents an instruction word, a shift-source operand and a data operand, together with a one-cycle strobe. One clock later the unit returns the packed result, an overflow flag and an illegal-operation flag. The shift amount comes from a five-bit immediate field of the instruction or from the low bits of the shift-source operand, depending on the operation. Register-file access and any sticky flag storage belong to the surrounding pipeline.

Top module: `simd_shift_unit`

## Requirements
- R1: An operation is legal only if instr[31:26] is 0x1F, instr[5:0] is 0x13, and the sub-opcode instr[10:6] is one of the 22 listed in R5 to R9. Any other instruction sets illegal to 1 and forces result to 0 and ovf to 0.
- R2: When in_valid is high at a rising edge, out_valid, result, ovf and illegal take that operation's values at the same edge. When in_valid is low, out_valid is 0 on the next cycle and result, ovf and illegal keep their values.
- R3: Immediate forms take the amount from instr[25:21]. Variable forms take it from shamt_src. For byte lanes only the low 3 bits are used, for halfword lanes the low 4 bits, and for the word the low 5 bits.
- R4: Lanes are packed with lane 0 in the least significant bits (byte lane i is bits 8i+7:8i, halfword lane i is bits 16i+15:16i). Each lane is shifted independently.
- R5: Wrapping left shift (byte 0x00 imm and 0x02 var; halfword 0x08 imm and 0x0A var) returns the low lane bits of lane << s. ovf is 1 if any lane's signed value times 2^s does not fit the lane as a signed number.
- R6: Saturating left shift (halfword 0x0C imm and 0x0E var; word 0x14 imm and 0x16 var) uses the same overflow test as R5. A lane that overflows is clamped to the signed maximum if it was non-negative, or to the signed minimum if it was negative. ovf is set as in R5.
- R7: Logical right shift (byte 0x01 imm and 0x03 var; halfword 0x19 imm and 0x1B var) fills each lane with zeros.
- R8: Arithmetic right shift (byte 0x04 imm and 0x06 var; halfword 0x09 imm and 0x0B var) fills each lane with copies of its sign bit.
- R9: Rounding right shift (byte 0x05 imm and 0x07 var; halfword 0x0D imm and 0x0F var; word 0x15 imm and 0x17 var) returns floor((v + 2^(s-1)) / 2^s) per lane, keeping the low lane bits, where v is the signed lane value. An amount of 0 returns the lane unchanged.
- R10: Right shifts of any kind, and illegal operations, never set ovf.
- R11: While rst_n is low at a rising edge, out_valid, result, ovf and illegal are cleared at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word (major code, sub-opcode, immediate amount) |
| shamt_src | input | 32 | Register operand that supplies the amount in variable forms |
| data_in | input | 32 | Packed data operand |
| out_valid | output | 1 | High for one cycle when a result is delivered |
| result | output | 32 | Packed shifted result |
| ovf | output | 1 | A left shift lost significant bits in some lane |
| illegal | output | 1 | The instruction was not a recognised shift operation |

## Verification
Every result and flag is due exactly one rising edge after the strobe that carried its operation. The bench drives each operation on a falling edge, waits for the next rising edge, and samples one nanosecond later. It then checks out_valid, result, ovf and illegal against a lane-by-lane integer model. In a following idle cycle it changes the inputs and confirms that out_valid drops and the registered outputs keep their values. The sweep covers every five-bit sub-opcode, every amount from 0 to 31, and several data patterns. For immediate forms the shift-source operand is filled with unrelated bits, and for variable forms the immediate field is filled with unrelated bits, so the amount source is exercised as well.

// File: rtl/simd_shift_pkg.sv
// Package: shared types and constants for the packed lane shift unit.
// Assumes a 32-bit datapath with lane widths of 8, 16 and 32 bits.
package simd_shift_pkg;

    localparam int          DATA_W      = 32;
    localparam int          AMT_W       = 5;
    localparam int          NUM_WIDTHS  = 3;
    localparam int          MIN_LANE_W  = 8;
    localparam logic [5:0]  MAJOR_GROUP = 6'h1F;
    localparam logic [5:0]  FUNC_SHIFT  = 6'h13;

    typedef enum logic [1:0] {
        LW_BYTE = 2'd0,
        LW_HALF = 2'd1,
        LW_WORD = 2'd2
    } lane_width_e;

    typedef enum logic [2:0] {
        SK_SHL = 3'd0,
        SK_SAT = 3'd1,
        SK_SRL = 3'd2,
        SK_SRA = 3'd3,
        SK_RND = 3'd4
    } shift_kind_e;

    typedef struct packed {
        logic        legal;
        lane_width_e width;
        shift_kind_e kind;
        logic        var_amt;
    } op_desc_t;

endpackage

// File: rtl/sss_decode.sv
// Module: sss_decode
// Decodes the instruction word into lane width, shift kind and amount
// source, and forms the shift amount masked to the lane's width.
// Assumes the instruction is valid only when the caller strobes it.
module sss_decode
    import simd_shift_pkg::*;
(
    input  logic [31:0]      instr,
    input  logic [31:0]      shamt_src,
    output op_desc_t         desc,
    output logic [AMT_W-1:0] amt
);

    logic [4:0]       sub_op;
    logic             major_ok;
    logic [AMT_W-1:0] raw_amt;
    logic             unused_fields;

    assign sub_op        = instr[10:6];
    assign major_ok      = (instr[31:26] == MAJOR_GROUP) && (instr[5:0] == FUNC_SHIFT);
    assign unused_fields = ^{instr[20:11], shamt_src[31:5]};

    // Map the sub-opcode to its lane width, kind and amount source.
    always_comb begin
        desc = '{legal: 1'b1, width: LW_BYTE, kind: SK_SHL, var_amt: 1'b0};
        case (sub_op)
            5'h00: desc = '{1'b1, LW_BYTE, SK_SHL, 1'b0};
            5'h02: desc = '{1'b1, LW_BYTE, SK_SHL, 1'b1};
            5'h01: desc = '{1'b1, LW_BYTE, SK_SRL, 1'b0};
            5'h03: desc = '{1'b1, LW_BYTE, SK_SRL, 1'b1};
            5'h04: desc = '{1'b1, LW_BYTE, SK_SRA, 1'b0};
            5'h06: desc = '{1'b1, LW_BYTE, SK_SRA, 1'b1};
            5'h05: desc = '{1'b1, LW_BYTE, SK_RND, 1'b0};
            5'h07: desc = '{1'b1, LW_BYTE, SK_RND, 1'b1};
            5'h08: desc = '{1'b1, LW_HALF, SK_SHL, 1'b0};
            5'h0A: desc = '{1'b1, LW_HALF, SK_SHL, 1'b1};
            5'h0C: desc = '{1'b1, LW_HALF, SK_SAT, 1'b0};
            5'h0E: desc = '{1'b1, LW_HALF, SK_SAT, 1'b1};
            5'h19: desc = '{1'b1, LW_HALF, SK_SRL, 1'b0};
            5'h1B: desc = '{1'b1, LW_HALF, SK_SRL, 1'b1};
            5'h09: desc = '{1'b1, LW_HALF, SK_SRA, 1'b0};
            5'h0B: desc = '{1'b1, LW_HALF, SK_SRA, 1'b1};
            5'h0D: desc = '{1'b1, LW_HALF, SK_RND, 1'b0};
            5'h0F: desc = '{1'b1, LW_HALF, SK_RND, 1'b1};
            5'h14: desc = '{1'b1, LW_WORD, SK_SAT, 1'b0};
            5'h16: desc = '{1'b1, LW_WORD, SK_SAT, 1'b1};
            5'h15: desc = '{1'b1, LW_WORD, SK_RND, 1'b0};
            5'h17: desc = '{1'b1, LW_WORD, SK_RND, 1'b1};
            default: desc.legal = 1'b0;
        endcase
        if (!major_ok) begin
            desc.legal = 1'b0;
        end
    end

    // Choose the amount source and keep only the bits the lane width allows.
    always_comb begin
        raw_amt = desc.var_amt ? shamt_src[AMT_W-1:0] : instr[25:21];
        case (desc.width)
            LW_BYTE: amt = {2'b00, raw_amt[2:0]};
            LW_HALF: amt = {1'b0, raw_amt[3:0]};
            default: amt = raw_amt;
        endcase
    end

endmodule

// File: rtl/sss_lane.sv
// Module: sss_lane
// Shifts one lane of LANE_W bits by an amount below LANE_W and reports
// whether a left shift lost significant bits.
// Assumes the amount is already masked to clog2(LANE_W) bits.
module sss_lane
    import simd_shift_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0]         lane_in,
    input  shift_kind_e               kind,
    input  logic [$clog2(LANE_W)-1:0] amt,
    output logic [LANE_W-1:0]         lane_out,
    output logic                      lane_ovf
);

    localparam int SW = $clog2(LANE_W);
    localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [2*LANE_W-1:0] wide;
    logic [2*LANE_W-1:0] shl;
    logic [LANE_W:0]     top_bits;
    logic                lost;
    logic [LANE_W-1:0]   sra;
    logic [LANE_W:0]     rnd_ext;
    logic [LANE_W:0]     rnd_pre;
    logic [LANE_W:0]     rnd_sum;
    logic [SW-1:0]       amt_m1;
    logic                unused_rnd_lsb;

    // Left shift in a double-width sign-extended field to see lost bits.
    always_comb begin
        wide     = {{LANE_W{lane_in[LANE_W-1]}}, lane_in};
        shl      = wide << amt;
        top_bits = shl[2*LANE_W-1:LANE_W-1];
        lost     = (|top_bits) && !(&top_bits);
    end

    // Plain and rounding arithmetic right shifts.
    always_comb begin
        sra     = $unsigned($signed(lane_in) >>> amt);
        amt_m1  = amt - 1'b1;
        rnd_ext = {lane_in[LANE_W-1], lane_in};
        rnd_pre = $unsigned($signed(rnd_ext) >>> amt_m1);
        rnd_sum = rnd_pre + {{LANE_W{1'b0}}, 1'b1};
    end

    assign unused_rnd_lsb = rnd_sum[0];

    // Select the lane result for the requested kind.
    always_comb begin
        case (kind)
            SK_SHL:  lane_out = shl[LANE_W-1:0];
            SK_SAT:  lane_out = lost ? (lane_in[LANE_W-1] ? NEG_MIN : POS_MAX)
                                     : shl[LANE_W-1:0];
            SK_SRL:  lane_out = lane_in >> amt;
            SK_SRA:  lane_out = sra;
            SK_RND:  lane_out = (amt == '0) ? lane_in : rnd_sum[LANE_W:1];
            default: lane_out = '0;
        endcase
    end

    // Overflow is only meaningful for left shifts.
    assign lane_ovf = lost && ((kind == SK_SHL) || (kind == SK_SAT));

endmodule

// File: rtl/sss_lane_bank.sv
// Module: sss_lane_bank
// Splits the data word into DATA_W/LANE_W lanes, shifts each lane on its
// own and repacks them in place; ORs the lane overflow flags.
// Assumes DATA_W is a multiple of LANE_W.
module sss_lane_bank
    import simd_shift_pkg::*;
#(
    parameter int BANK_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [BANK_W-1:0]         data,
    input  shift_kind_e               kind,
    input  logic [$clog2(LANE_W)-1:0] amt,
    output logic [BANK_W-1:0]         packed_out,
    output logic                      any_ovf
);

    localparam int N_LANES = BANK_W / LANE_W;

    logic [N_LANES-1:0] ovf_vec;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        sss_lane #(.LANE_W(LANE_W)) u_lane (
            .lane_in  (data[i*LANE_W +: LANE_W]),
            .kind     (kind),
            .amt      (amt),
            .lane_out (packed_out[i*LANE_W +: LANE_W]),
            .lane_ovf (ovf_vec[i])
        );
    end

    // Any lane losing bits flags the whole operation.
    assign any_ovf = |ovf_vec;

endmodule

// File: rtl/simd_shift_unit.sv
// Module: simd_shift_unit
// Top of the packed lane shift unit: decodes the instruction, runs one
// lane bank per lane width, picks the bank for the decoded width and
// registers result and flags one cycle after the input strobe.
// Assumes a synchronous active-low reset and one operation per strobe.
module simd_shift_unit
    import simd_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [31:0]       shamt_src,
    input  logic [31:0]       data_in,
    output logic              out_valid,
    output logic [31:0]       result,
    output logic              ovf,
    output logic              illegal
);

    op_desc_t                              desc;
    logic [AMT_W-1:0]                      amt;
    logic [NUM_WIDTHS-1:0][DATA_W-1:0]     bank_res;
    logic [NUM_WIDTHS-1:0]                 bank_ovf;
    logic [DATA_W-1:0]                     sel_res;
    logic                                  sel_ovf;

    sss_decode u_decode (
        .instr     (instr),
        .shamt_src (shamt_src),
        .desc      (desc),
        .amt       (amt)
    );

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_bank
        localparam int LW = MIN_LANE_W << g;
        sss_lane_bank #(.BANK_W(DATA_W), .LANE_W(LW)) u_bank (
            .data       (data_in),
            .kind       (desc.kind),
            .amt        (amt[$clog2(LW)-1:0]),
            .packed_out (bank_res[g]),
            .any_ovf    (bank_ovf[g])
        );
    end

    // Pick the bank that matches the decoded lane width.
    always_comb begin
        case (desc.width)
            LW_BYTE: begin sel_res = bank_res[0]; sel_ovf = bank_ovf[0]; end
            LW_HALF: begin sel_res = bank_res[1]; sel_ovf = bank_ovf[1]; end
            default: begin sel_res = bank_res[2]; sel_ovf = bank_ovf[2]; end
        endcase
    end

    // Register the outcome on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= desc.legal ? sel_res : '0;
                ovf     <= desc.legal && sel_ovf;
                illegal <= !desc.legal;
            end
        end
    end

endmodule

// File: rtl/simd_shift_unit_checks.sv
// Module: simd_shift_unit_checks
// Property checker for simd_shift_unit, attached by bind below.
// Assumes it sees the top's ports only.
module simd_shift_unit_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        ovf,
    input logic        illegal
);

    logic       major_ok;
    logic [4:0] sub_op;
    logic       is_right;
    logic       is_word_sat;

    assign major_ok = (instr[31:26] == 6'h1F) && (instr[5:0] == 6'h13);
    assign sub_op   = instr[10:6];

    // Classify the sub-opcode by the requirement lists.
    always_comb begin
        case (sub_op)
            5'h01, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07,
            5'h19, 5'h1B, 5'h09, 5'h0B, 5'h0D, 5'h0F,
            5'h15, 5'h17: is_right = 1'b1;
            default:      is_right = 1'b0;
        endcase
        is_word_sat = major_ok && ((sub_op == 5'h14) || (sub_op == 5'h16));
    end

    // R11: reset clears the outputs at the next edge.
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 32'h0 && !ovf && !illegal));

    // R2: a strobe yields out_valid one cycle later.
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: without a strobe, outputs hold and out_valid is low.
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(ovf) && $stable(illegal)));

    // R1: an illegal operation yields zero result and no overflow.
    assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (result == 32'h0 && !ovf));

    // R10: right shifts never report overflow.
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_right) |=> !ovf);

    // R6: a word saturating shift that overflows returns a clamp value.
    assert_word_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_word_sat) |=> (!ovf || result == 32'h7FFFFFFF || result == 32'h80000000));

endmodule

bind simd_shift_unit simd_shift_unit_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .out_valid (out_valid),
    .result    (result),
    .ovf       (ovf),
    .illegal   (illegal)
);

// File: tb/simd_shift_unit_tb.sv
module simd_shift_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] shamt_src = '0;
    logic [31:0] data_in = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf;
    logic        illegal;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'hACE1_2357;

    always #2 clk = ~clk;

    simd_shift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .shamt_src(shamt_src), .data_in(data_in), .out_valid(out_valid),
        .result(result), .ovf(ovf), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Reference table from R5..R9: width 8/16/32, kind 0 shl,1 sat,2 srl,3 sra,4 rnd.
    function automatic bit ref_decode(input logic [4:0] sub, output int w, output int k, output bit v);
        w = 8; k = 0; v = 0;
        case (sub)
            5'h00: begin w=8;  k=0; v=0; end  5'h02: begin w=8;  k=0; v=1; end
            5'h01: begin w=8;  k=2; v=0; end  5'h03: begin w=8;  k=2; v=1; end
            5'h04: begin w=8;  k=3; v=0; end  5'h06: begin w=8;  k=3; v=1; end
            5'h05: begin w=8;  k=4; v=0; end  5'h07: begin w=8;  k=4; v=1; end
            5'h08: begin w=16; k=0; v=0; end  5'h0A: begin w=16; k=0; v=1; end
            5'h0C: begin w=16; k=1; v=0; end  5'h0E: begin w=16; k=1; v=1; end
            5'h19: begin w=16; k=2; v=0; end  5'h1B: begin w=16; k=2; v=1; end
            5'h09: begin w=16; k=3; v=0; end  5'h0B: begin w=16; k=3; v=1; end
            5'h0D: begin w=16; k=4; v=0; end  5'h0F: begin w=16; k=4; v=1; end
            5'h14: begin w=32; k=1; v=0; end  5'h16: begin w=32; k=1; v=1; end
            5'h15: begin w=32; k=4; v=0; end  5'h17: begin w=32; k=4; v=1; end
            default: return 0;
        endcase
        return 1;
    endfunction

    function automatic longint fdiv(input longint a, input longint b);
        return (a >= 0) ? a / b : -((-a + b - 1) / b);
    endfunction

    // Integer model of one operation.
    task automatic model(input logic [31:0] ins, input logic [31:0] src, input logic [31:0] d,
                         output logic [31:0] res, output logic ov, output logic ill, output int k, output bit v);
        int w;
        int s;
        longint mask, maxv, minv, dl;
        bit ok;
        res = '0; ov = 0; ill = 0;
        ok = ref_decode(ins[10:6], w, k, v);
        if (!ok || ins[31:26] != 6'h1F || ins[5:0] != 6'h13) begin
            ill = 1; k = -1;
            return;
        end
        s = v ? int'(src[4:0]) % w : int'(ins[25:21]) % w;
        mask = (64'sd1 <<< w) - 1;
        maxv = (64'sd1 <<< (w - 1)) - 1;
        minv = -(64'sd1 <<< (w - 1));
        dl = longint'({32'b0, d});
        for (int i = 0; i < 32 / w; i++) begin
            longint u, sv, p, r;
            u = (dl >> (i * w)) & mask;
            sv = (u > maxv) ? u - (mask + 1) : u;
            p = sv * (64'sd1 <<< s);
            r = 0;
            case (k)
                0: begin r = p; if (p > maxv || p < minv) ov = 1; end
                1: begin
                    if (p > maxv || p < minv) begin ov = 1; r = (sv < 0) ? minv : maxv; end
                    else r = p;
                end
                2: r = u / (64'sd1 <<< s);
                3: r = fdiv(sv, 64'sd1 <<< s);
                default: r = (s == 0) ? u : fdiv(sv + (64'sd1 <<< (s - 1)), 64'sd1 <<< s);
            endcase
            res = res | 32'((r & mask) << (i * w));
        end
    endtask

    task automatic run_op(input logic [31:0] ins, input logic [31:0] src, input logic [31:0] d);
        logic [31:0] er;
        logic eo, ei;
        int k;
        bit v;
        string tag;
        model(ins, src, d, er, eo, ei, k, v);
        @(negedge clk);
        instr = ins; shamt_src = src; data_in = d; in_valid = 1'b1;
        @(posedge clk);
        #1;
        case (k)
            0: tag = "R5";  1: tag = "R6";  2: tag = "R7";
            3: tag = "R8";  4: tag = "R9";  default: tag = "R1";
        endcase
        if (v) tag = {tag, "/R3"};
        chk({tag, " result"}, result, er);
        chk((k >= 2) ? "R10 ovf" : {tag, " ovf"}, {31'b0, ovf}, {31'b0, eo});
        chk("R1 illegal", {31'b0, illegal}, {31'b0, ei});
        chk("R2 out_valid", {31'b0, out_valid}, 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] imm);
        return {6'h1F, imm, 10'h155, sub, 6'h13};
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [8];
        logic [31:0] held;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h7F80_01FF; pats[3] = 32'h8000_7FFF;
        pats[4] = 32'h4020_C0E0; pats[5] = 32'h1234_ABCD;
        pats[6] = 32'h3FFF_C001; pats[7] = 32'h0180_7E81;

        repeat (3) @(posedge clk);
        #1;
        // R11: outputs cleared by reset.
        chk("R11 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R11 result", result, 32'd0);
        chk("R11 ovf", {31'b0, ovf}, 32'd0);
        chk("R11 illegal", {31'b0, illegal}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: byte lanes don't carry into neighbours; 0x80 lanes overflow.
        run_op(mk(5'h00, 5'd1), 32'h0, 32'h0180_0180);
        chk("R4 lane packing", result, 32'h0200_0200);
        chk("R4/R5 ovf", {31'b0, ovf}, 32'd1);

        // R9: rounding ties away upward (127 >> 1 rounds to 64).
        run_op(mk(5'h05, 5'd1), 32'h0, 32'h7F7F_7F7F);
        chk("R9 round", result, 32'h4040_4040);

        // R1: wrong function code is illegal.
        run_op({6'h1F, 5'd2, 10'h0, 5'h00, 6'h12}, 32'h0, 32'h1234_5678);
        chk("R1 bad major", {31'b0, illegal}, 32'd1);

        // R2: idle cycle holds outputs and drops out_valid.
        run_op(mk(5'h14, 5'd3), 32'h0, 32'h0000_1234);
        held = result;
        @(negedge clk);
        instr = mk(5'h01, 5'd4); data_in = 32'hFFFF_FFFF; in_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R2 idle hold", result, held);

        // Sweep every sub-opcode, amount and pattern.
        for (int sub = 0; sub < 32; sub++) begin
            for (int a = 0; a < 32; a++) begin
                for (int p = 0; p < 8; p++) begin
                    logic [31:0] src;
                    logic [31:0] ins;
                    int w; int k; bit v; bit ok;
                    lfsr = next_rand(lfsr);
                    ok = ref_decode(5'(sub), w, k, v);
                    if (ok && v) begin
                        ins = mk(5'(sub), ~5'(a));
                        src = {lfsr[31:5], 5'(a)};
                    end else begin
                        ins = mk(5'(sub), 5'(a));
                        src = lfsr;
                    end
                    run_op(ins, src, pats[p]);
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule